// File: doc/BRIEF.md
# Ones and Transition Count Response Compactor

This block sits at the output of a single-output circuit under test during self-test and reduces a serial response stream to two numbers. One number is how many response bits were 1. The other is how many times the stream changed value between two consecutive bits, counting both rising and falling changes. A one-bit history register keeps the previous accepted bit, and an XOR with the current bit marks a change.

A run opens with a start strobe. Response bits then arrive with a valid qualifier, possibly with idle cycles between them. A run closes with an end-of-stream strobe. The cycle after the end strobe, a done flag rises together with a pass flag. Pass is set only when both counts equal the fault-free golden values presented on two inputs. The counts, done and pass then hold until the next start. Both counters saturate at their all-ones value, so a stream longer than the configured maximum cannot wrap back to a matching signature.

Top module: `resp_count_ora`

## Requirements
- R1: While reset is low, and after it is released with no start seen, both counts read 0 and done and pass read 0.
- R2: After a run, the ones count equals the number of accepted bits whose value was 1.
- R3: After a run, the transition count equals the number of accepted bits that differ from the bit accepted before them in the same run. The first accepted bit after a start never counts, and idle cycles with the valid input low do not break the adjacency of two accepted bits.
- R4: A start strobe clears both counts, the history bit, done and pass, all visible the next cycle. A bit or end strobe in the same cycle as a start is ignored.
- R5: Done reads 1 starting the cycle after an accepted end strobe and stays 1, with pass unchanged, until the next start.
- R6: Pass is 1 exactly when the final ones count equals the golden ones input and the final transition count equals the golden transition input, both sampled in the end-strobe cycle. A mismatch in either gives pass 0.
- R7: A valid bit presented in the same cycle as the end strobe is counted and is part of the pass decision.
- R8: Valid bits and end strobes presented before the first start, or after done has risen, change neither count nor the done or pass flags.
- R9: Each count stops at 2^CW-1, where CW is the smallest width that holds MAX_LEN, and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| startStrb | input | 1 | Opens a run and clears all results |
| bitValid | input | 1 | Qualifies bitVal in this cycle |
| bitVal | input | 1 | Response bit from the circuit under test |
| endStrb | input | 1 | Closes the run; the bit in this cycle is still counted |
| goldOnes | input | CW | Fault-free ones count |
| goldTrans | input | CW | Fault-free transition count |
| onesCnt | output | CW | Running ones count |
| transCnt | output | CW | Running transition count |
| doneFlag | output | 1 | Run finished, result valid |
| passFlag | output | 1 | Both counts matched their golden values |

## Verification
The two functions that can fall in the same cycle are counting the last response bit and closing the run on the end strobe. The bench drives streams where the final bit and the end strobe share a cycle and streams where the end strobe comes alone, with golden values chosen so that pass depends on that last bit being included; a pass decision made on the stale count would flip the flag. A start arriving together with a valid bit and an end strobe is also driven, and the bench requires the cleared state with no count taken.

// File: rtl/resp_ora_pkg.sv
package resp_ora_pkg;

  // Strobes from control to datapath, one cycle wide each.
  typedef struct packed {
    logic clr;   // clear counts, history and pass
    logic take;  // accept bitVal this cycle
    logic fin;   // latch the pass decision
  } ora_strb_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } ora_state_t;

endpackage

// File: rtl/resp_sat_ctr.sv
module resp_sat_ctr #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cntNext
);

  localparam logic [CW-1:0] CNT_TOP = {CW{1'b1}};

  logic atTop;

  assign atTop = (cnt == CNT_TOP);

  always_comb begin
    if (clr) begin
      cntNext = '0;
    end else if (inc && !atTop) begin
      cntNext = cnt + 1'b1;
    end else begin
      cntNext = cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else begin
      cnt <= cntNext;
    end
  end

endmodule

// File: rtl/resp_ora_ctrl.sv
module resp_ora_ctrl
  import resp_ora_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startStrb,
  input  logic      bitValid,
  input  logic      endStrb,
  output ora_strb_t strb,
  output logic      running,
  output logic      doneFlag
);

  ora_state_t state;
  ora_state_t stateNext;

  always_comb begin
    strb      = '0;
    stateNext = state;
    if (startStrb) begin
      // start wins over everything else in its cycle
      strb.clr  = 1'b1;
      stateNext = ST_RUN;
    end else if (state == ST_RUN) begin
      strb.take = bitValid;
      if (endStrb) begin
        strb.fin  = 1'b1;
        stateNext = ST_DONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  assign running  = (state == ST_RUN);
  assign doneFlag = (state == ST_DONE);

endmodule

// File: rtl/resp_ora_dp.sv
module resp_ora_dp
  import resp_ora_pkg::*;
#(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rstN,
  input  ora_strb_t     strb,
  input  logic          bitVal,
  input  logic [CW-1:0] goldOnes,
  input  logic [CW-1:0] goldTrans,
  output logic [CW-1:0] onesCnt,
  output logic [CW-1:0] transCnt,
  output logic          passFlag
);

  localparam int NUM_CTR = 2;

  logic          prevBit;
  logic          histValid;
  logic          isOne;
  logic          isChange;
  logic [NUM_CTR-1:0]  incVec;
  logic [CW-1:0] cntQ    [NUM_CTR];
  logic [CW-1:0] cntNext [NUM_CTR];
  logic          matchAll;

  assign isOne    = strb.take && bitVal;
  assign isChange = strb.take && histValid && (bitVal ^ prevBit);
  assign incVec   = {isChange, isOne};

  for (genvar g = 0; g < NUM_CTR; g++) begin : gen_ctr
    resp_sat_ctr #(.CW(CW)) ctr_i (
      .clk     (clk),
      .rstN    (rstN),
      .clr     (strb.clr),
      .inc     (incVec[g]),
      .cnt     (cntQ[g]),
      .cntNext (cntNext[g])
    );
  end

  assign onesCnt  = cntQ[0];
  assign transCnt = cntQ[1];

  // Compare against next values so a bit arriving with the end strobe counts.
  assign matchAll = (cntNext[0] == goldOnes) && (cntNext[1] == goldTrans);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevBit   <= 1'b0;
      histValid <= 1'b0;
      passFlag  <= 1'b0;
    end else begin
      if (strb.clr) begin
        histValid <= 1'b0;
        passFlag  <= 1'b0;
      end else begin
        if (strb.take) begin
          prevBit   <= bitVal;
          histValid <= 1'b1;
        end
        if (strb.fin) begin
          passFlag <= matchAll;
        end
      end
    end
  end

endmodule

// File: rtl/resp_count_ora.sv
module resp_count_ora
  import resp_ora_pkg::*;
#(
  parameter  int MAX_LEN = 1024,
  localparam int CW      = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startStrb,
  input  logic          bitValid,
  input  logic          bitVal,
  input  logic          endStrb,
  input  logic [CW-1:0] goldOnes,
  input  logic [CW-1:0] goldTrans,
  output logic [CW-1:0] onesCnt,
  output logic [CW-1:0] transCnt,
  output logic          doneFlag,
  output logic          passFlag
);

  ora_strb_t strb;
  logic      running;

  resp_ora_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .startStrb (startStrb),
    .bitValid  (bitValid),
    .endStrb   (endStrb),
    .strb      (strb),
    .running   (running),
    .doneFlag  (doneFlag)
  );

  resp_ora_dp #(.CW(CW)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .bitVal    (bitVal),
    .goldOnes  (goldOnes),
    .goldTrans (goldTrans),
    .onesCnt   (onesCnt),
    .transCnt  (transCnt),
    .passFlag  (passFlag)
  );

endmodule

// File: rtl/resp_count_ora_chk.sv
module resp_count_ora_chk #(
  parameter int CW = 11
) (
  input logic          clk,
  input logic          rstN,
  input logic          startStrb,
  input logic          bitValid,
  input logic          bitVal,
  input logic          endStrb,
  input logic          running,
  input logic [CW-1:0] onesCnt,
  input logic [CW-1:0] transCnt,
  input logic          doneFlag,
  input logic          passFlag
);

  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    startStrb |=> (onesCnt == '0) && (transCnt == '0) && !doneFlag && !passFlag); // R4

  AST_ONE_ADDS: assert property (@(posedge clk) disable iff (!rstN)
    (running && !startStrb && bitValid && bitVal && (onesCnt != TOP))
      |=> (onesCnt == $past(onesCnt) + 1'b1)); // R2

  AST_IDLE_GAP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (running && !startStrb && !bitValid) |=> $stable(onesCnt) && $stable(transCnt)); // R3

  AST_END_GIVES_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (running && !startStrb && endStrb) |=> doneFlag); // R5

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !startStrb) |=> doneFlag && $stable(passFlag)); // R5

  AST_OUTSIDE_RUN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !startStrb) |=> $stable(onesCnt) && $stable(transCnt)); // R8

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    ((onesCnt == TOP) && !startStrb) |=> (onesCnt == TOP)); // R9

  AST_NO_WRAP_TRANS: assert property (@(posedge clk) disable iff (!rstN)
    ((transCnt == TOP) && !startStrb) |=> (transCnt == TOP)); // R9

  AST_PASS_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    passFlag |-> doneFlag); // R6

endmodule

bind resp_count_ora resp_count_ora_chk #(.CW(CW)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .startStrb (startStrb),
  .bitValid  (bitValid),
  .bitVal    (bitVal),
  .endStrb   (endStrb),
  .running   (running),
  .onesCnt   (onesCnt),
  .transCnt  (transCnt),
  .doneFlag  (doneFlag),
  .passFlag  (passFlag)
);

// File: tb/resp_count_ora_tb_top.sv
module resp_count_ora_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_LEN_TB = 20;
  localparam int CW_TB      = $clog2(MAX_LEN_TB + 1);
  localparam int SAT_TB     = (1 << CW_TB) - 1;

  typedef struct packed {
    logic [7:0]       len;
    logic [31:0]      bits;   // right aligned, first bit sent is bits[len-1]
    logic [CW_TB-1:0] gOnes;
    logic [CW_TB-1:0] gTrans;
    logic             withEnd; // end strobe shares the last bit's cycle
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{8'd7,  32'b0101100,    5'd3, 5'd4, 1'b0},
    '{8'd7,  32'b0101100,    5'd3, 5'd5, 1'b0},
    '{8'd4,  32'b1111,       5'd4, 5'd0, 1'b1},
    '{8'd10, 32'b1010101010, 5'd5, 5'd9, 1'b1},
    '{8'd1,  32'b0,          5'd0, 5'd0, 1'b0},
    '{8'd1,  32'b1,          5'd1, 5'd1, 1'b1}
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             startStrb = 1'b0;
  logic             bitValid = 1'b0;
  logic             bitVal = 1'b0;
  logic             endStrb = 1'b0;
  logic [CW_TB-1:0] goldOnes = '0;
  logic [CW_TB-1:0] goldTrans = '0;
  logic [CW_TB-1:0] onesCnt;
  logic [CW_TB-1:0] transCnt;
  logic             doneFlag;
  logic             passFlag;

  int errCnt = 0;
  int chkCnt = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  resp_count_ora #(.MAX_LEN(MAX_LEN_TB)) dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .startStrb (startStrb),
    .bitValid  (bitValid),
    .bitVal    (bitVal),
    .endStrb   (endStrb),
    .goldOnes  (goldOnes),
    .goldTrans (goldTrans),
    .onesCnt   (onesCnt),
    .transCnt  (transCnt),
    .doneFlag  (doneFlag),
    .passFlag  (passFlag)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    chkCnt++;
    if (act != exp) begin
      errCnt++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int modelOnes(input logic [127:0] b, input int len);
    int n = 0;
    for (int i = 0; i < len; i++) n += int'(b[i]);
    return (n > SAT_TB) ? SAT_TB : n;
  endfunction

  function automatic int modelTrans(input logic [127:0] b, input int len);
    int n = 0;
    for (int i = 1; i < len; i++) n += int'(b[i] ^ b[i-1]);
    return (n > SAT_TB) ? SAT_TB : n;
  endfunction

  // Drives a whole run; returns at the negedge where done is already visible.
  task automatic sendStream(input logic [127:0] b, input int len,
                            input bit endWithLast, input bit gaps);
    @(negedge clk);
    startStrb = 1'b1;
    @(negedge clk);
    startStrb = 1'b0;
    for (int i = 0; i < len; i++) begin
      bitValid = 1'b1;
      bitVal   = b[len-1-i];
      endStrb  = endWithLast && (i == len - 1);
      @(negedge clk);
      if (gaps) begin
        bitValid = 1'b0;
        endStrb  = 1'b0;
        bitVal   = ~bitVal;
        @(negedge clk);
      end
    end
    bitValid = 1'b0;
    if (!endWithLast) begin
      endStrb = 1'b1;
      @(negedge clk);
    end
    endStrb = 1'b0;
  endtask

  task automatic checkRun(input string tag, input logic [127:0] b, input int len,
                          input int gO, input int gT);
    int eo;
    int et;
    eo = modelOnes(b, len);
    et = modelTrans(b, len);
    check({tag, " R2"}, "onesCnt", int'(onesCnt), eo);
    check({tag, " R3"}, "transCnt", int'(transCnt), et);
    check({tag, " R5"}, "doneFlag", int'(doneFlag), 1);
    check({tag, " R6"}, "passFlag", int'(passFlag), int'((eo == gO) && (et == gT)));
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      chkCnt++;
      errCnt++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end

  initial begin
    logic [127:0] b;
    int savedOnes;
    int savedTrans;
    int savedPass;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "onesCnt in reset", int'(onesCnt), 0);
    check("R1", "doneFlag in reset", int'(doneFlag), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "transCnt after reset", int'(transCnt), 0);
    check("R1", "passFlag after reset", int'(passFlag), 0);

    // R8: bits and end strobe before any start are ignored
    bitValid = 1'b1; bitVal = 1'b1;
    repeat (3) @(negedge clk);
    endStrb = 1'b1;
    @(negedge clk);
    bitValid = 1'b0; endStrb = 1'b0;
    @(negedge clk);
    check("R8", "onesCnt before start", int'(onesCnt), 0);
    check("R8", "doneFlag before start", int'(doneFlag), 0);

    // Table walk: R2 R3 R5 R6, R7 on rows with withEnd set
    for (int v = 0; v < NVEC; v++) begin
      b = 128'(VECS[v].bits);
      goldOnes  = VECS[v].gOnes;
      goldTrans = VECS[v].gTrans;
      sendStream(b, int'(VECS[v].len), VECS[v].withEnd, 1'b0);
      goldOnes = '0; goldTrans = '0;
      checkRun(VECS[v].withEnd ? "R7 vec" : "vec", b, int'(VECS[v].len),
               int'(VECS[v].gOnes), int'(VECS[v].gTrans));
    end

    // R7: golden only matches if the bit sent with end strobe is counted
    goldOnes = 5'd3; goldTrans = 5'd1;
    sendStream(128'b0111, 4, 1'b1, 1'b0);
    check("R7", "passFlag with last bit on end", int'(passFlag), 1);
    check("R7", "onesCnt with last bit on end", int'(onesCnt), 3);

    // R5 and R8: after done, bits and end strobes change nothing
    savedOnes = int'(onesCnt); savedTrans = int'(transCnt); savedPass = int'(passFlag);
    goldOnes = '0; goldTrans = '0;
    bitValid = 1'b1; bitVal = 1'b0;
    @(negedge clk);
    bitVal = 1'b1; endStrb = 1'b1;
    @(negedge clk);
    bitValid = 1'b0; endStrb = 1'b0;
    repeat (3) @(negedge clk);
    check("R8", "onesCnt after done", int'(onesCnt), savedOnes);
    check("R8", "transCnt after done", int'(transCnt), savedTrans);
    check("R5", "doneFlag holds", int'(doneFlag), 1);
    check("R5", "passFlag holds", int'(passFlag), savedPass);

    // R4: start together with bit and end; both ignored, state cleared
    @(negedge clk);
    startStrb = 1'b1; bitValid = 1'b1; bitVal = 1'b1; endStrb = 1'b1;
    @(negedge clk);
    startStrb = 1'b0; bitValid = 1'b0; endStrb = 1'b0;
    check("R4", "onesCnt after start", int'(onesCnt), 0);
    check("R4", "transCnt after start", int'(transCnt), 0);
    check("R4", "doneFlag after start", int'(doneFlag), 0);
    check("R4", "passFlag after start", int'(passFlag), 0);
    // first accepted bit 0 after start must not be a change from the ignored 1
    bitValid = 1'b1; bitVal = 1'b0;
    @(negedge clk);
    bitValid = 1'b0;
    @(negedge clk);
    check("R3", "first bit not a transition", int'(transCnt), 0);
    check("R4", "start-cycle bit not counted", int'(onesCnt), 0);
    check("R4", "start-cycle end ignored", int'(doneFlag), 0);

    // R3: idle gaps between bits keep adjacency
    b = 128'b1001101;
    goldOnes = 5'd4; goldTrans = 5'd4;
    sendStream(b, 7, 1'b0, 1'b1);
    checkRun("R3 gaps", b, 7, 4, 4);

    // R9: both counters saturate
    b = '0;
    for (int i = 0; i < 70; i++) b[i] = (i % 2 == 0);
    goldOnes = 5'(SAT_TB); goldTrans = 5'(SAT_TB);
    sendStream(b, 70, 1'b1, 1'b0);
    check("R9", "onesCnt saturates", int'(onesCnt), SAT_TB);
    check("R9", "transCnt saturates", int'(transCnt), SAT_TB);
    check("R9", "passFlag at saturation", int'(passFlag), 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

endmodule